// File: doc/BRIEF.md
# Givens Rotation Generate-and-Apply Cell

This block is one fixed-point processing cell of a QR-decomposition array. It takes a pivot pair from one column, a from the upper row and b from the lower row. It exports the exact squared magnitude a² + b² to an external reciprocal-square-root evaluator. When that evaluator returns its result, the cell forms the rotation coefficients c and s and the rotated diagonal value. It also forwards the reciprocal of that diagonal, which the back-substitution stage needs. The cell then holds c and s and applies the transposed 2x2 rotation to each column pair of the same two rows that it is given. Applying the rotation to the pivot column drives the lower element to zero.

All three results come from multiplications by the one reciprocal-square-root input. The cell has no divider, no square root and no iterative rotation unit. The order in which rows and columns are visited belongs to the array controller; the cell does not see it. That order works from the bottom row upward to the row just below the pivot, and covers only the columns from the pivot column rightward.

A three-state machine sequences the cell:
- ST_IDLE means no coefficients are loaded yet.
- ST_WAIT means a nonzero pivot has been taken and the cell waits for the reciprocal square root.
- ST_READY means the coefficients are held and rotations may be applied.

The transitions are as follows:
- A pivot strobe moves the cell from any state to ST_WAIT, or to ST_READY when both pivot elements are zero.
- A reciprocal-square-root strobe moves the cell from ST_WAIT to ST_READY.
- Any other input leaves the state unchanged.

Number formats:
- Data values (a, b, row elements, diagonal) are signed 16-bit with 12 fractional bits.
- The reciprocal square root and the diagonal reciprocal are unsigned 16-bit with 12 fractional bits.
- c and s are signed 16-bit with 14 fractional bits, so 1.0 is 16384.

Every rounded result is computed the same way. The cell forms the exact product or sum, adds half of the dropped LSB weight, and shifts right arithmetically, so ties round toward plus infinity. It then clamps the result to [-32768, 32767].

Top module: `givens_cell`

## Requirements
- R1: One cycle after a pivot strobe with a or b nonzero, sq_valid is high for exactly one cycle and sq_sum equals a*a + b*b as an exact unsigned integer of the raw values. gen_valid stays low in that cycle.
- R2: In ST_WAIT, a rsr_valid strobe makes gen_valid high for one cycle on the next cycle. In that cycle cos_out = round_sat((a*rsr) >> 10) and sin_out = round_sat((b*rsr) >> 10), using the raw a, b and rsr_val.
- R3: In the same cycle as the gen_valid of R2, diag_out = round_sat((sq_sum*rsr) >> 24) and diag_recip equals the rsr_val that was accepted.
- R4: In ST_READY, a rot_valid strobe with upper element x and lower element y gives out_valid for one cycle on the next cycle. In that cycle out_top = round_sat((c*x + s*y) >> 14) and out_bot = round_sat((c*y - s*x) >> 14).
- R5: A pivot strobe with a = b = 0 gives, on the next cycle, gen_valid high, cos_out = 16384, sin_out = 0, diag_out = 0 and diag_recip = 0, with sq_valid low. Rotations that follow return x and y unchanged.
- R6: cos_out, sin_out, diag_out and diag_recip change only in a cycle where gen_valid is high. Any number of rotations reuse the held coefficients.
- R7: The cell ignores rot_valid outside ST_READY: out_valid stays low and out_top and out_bot keep their values. It also ignores rsr_valid outside ST_WAIT: gen_valid stays low and the coefficients keep their values.
- R8: A pivot strobe restarts the cell from any state. It takes priority over a rsr_valid or rot_valid in the same cycle, and the other strobe has no effect.
- R9: While reset is applied and after it, every output is zero and the state is ST_IDLE.
- R10: A rotation result outside the 16-bit range clamps to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| piv_valid | input | 1 | Pivot pair strobe |
| piv_a | input | 16 | Upper pivot element, signed Q3.12 |
| piv_b | input | 16 | Lower pivot element, signed Q3.12 |
| sq_valid | output | 1 | Squared magnitude valid pulse |
| sq_sum | output | 32 | a*a + b*b, unsigned, 24 fractional bits |
| rsr_valid | input | 1 | Reciprocal square root strobe |
| rsr_val | input | 16 | Reciprocal square root of sq_sum, unsigned Q4.12 |
| gen_valid | output | 1 | New coefficients valid pulse |
| cos_out | output | 16 | Rotation cosine, signed Q1.14, held |
| sin_out | output | 16 | Rotation sine, signed Q1.14, held |
| diag_out | output | 16 | Rotated diagonal element, signed Q3.12, held |
| diag_recip | output | 16 | Diagonal reciprocal for back substitution, unsigned Q4.12, held |
| rot_valid | input | 1 | Column pair strobe |
| rot_top | input | 16 | Upper row element x, signed Q3.12 |
| rot_bot | input | 16 | Lower row element y, signed Q3.12 |
| out_valid | output | 1 | Rotated pair valid pulse |
| out_top | output | 16 | Rotated upper element |
| out_bot | output | 16 | Rotated lower element |

## Verification
A wrong state shows up on the first strobe that follows it.
- A cell stuck in ST_WAIT drops a rotation, so out_valid is missing one cycle after rot_valid.
- A cell that leaves ST_WAIT too early raises gen_valid without a rsr_valid.
- A cell that skips the zero-pivot path raises sq_valid where gen_valid was due.

Coefficients that are corrupted or not held give wrong out_top and out_bot on the very next rotation. For that reason the directed tests check coefficients and rotated pairs in the cycle right after each strobe, and again after further strobes that must be ignored.

// File: rtl/givens_pkg.sv
package givens_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } gc_state_e;
endpackage

// File: rtl/gc_round_sat.sv
module gc_round_sat #(
    parameter int IW = 33,
    parameter int SH = 10,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam int EW = IW + 1;
    localparam logic signed [EW-1:0] HALF = EW'(2**(SH-1));
    localparam logic signed [EW-1:0] MAXV = EW'(2**(OW-1) - 1);
    localparam logic signed [EW-1:0] MINV = EW'(-(2**(OW-1)));

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] rnd;
    logic signed [EW-1:0] shf;

    assign ext = {din[IW-1], din};
    assign rnd = ext + HALF;
    assign shf = rnd >>> SH;

    always_comb begin
        if (shf > MAXV)      dout = MAXV[OW-1:0];
        else if (shf < MINV) dout = MINV[OW-1:0];
        else                 dout = shf[OW-1:0];
    end
endmodule

// File: rtl/gc_boundary.sv
module gc_boundary #(
    parameter int DW = 16,
    parameter int DF = 12,
    parameter int CF = 14,
    parameter int RW = 16,
    parameter int RF = 12
) (
    input  logic signed [DW-1:0]   a,
    input  logic signed [DW-1:0]   b,
    input  logic        [2*DW-1:0] sumsq,
    input  logic        [RW-1:0]   rsr,
    output logic signed [DW-1:0]   c_val,
    output logic signed [DW-1:0]   s_val,
    output logic signed [DW-1:0]   r_val
);
    localparam int CPW   = DW + RW + 1;
    localparam int RPW   = 2*DW + RW + 2;
    localparam int SH_CS = DF + RF - CF;
    localparam int SH_R  = DF + RF;

    logic signed [RW:0]       rsr_s;
    logic signed [2*DW:0]     sum_s;
    logic signed [CPW-1:0]    pa;
    logic signed [CPW-1:0]    pb;
    logic signed [RPW-1:0]    pr;

    assign rsr_s = {1'b0, rsr};
    assign sum_s = {1'b0, sumsq};
    assign pa    = CPW'(a) * CPW'(rsr_s);
    assign pb    = CPW'(b) * CPW'(rsr_s);
    assign pr    = RPW'(sum_s) * RPW'(rsr_s);

    gc_round_sat #(.IW(CPW), .SH(SH_CS), .OW(DW)) u_rs_c (.din(pa), .dout(c_val));
    gc_round_sat #(.IW(CPW), .SH(SH_CS), .OW(DW)) u_rs_s (.din(pb), .dout(s_val));
    gc_round_sat #(.IW(RPW), .SH(SH_R),  .OW(DW)) u_rs_r (.din(pr), .dout(r_val));
endmodule

// File: rtl/gc_rotator.sv
module gc_rotator #(
    parameter int DW = 16,
    parameter int CF = 14
) (
    input  logic signed [DW-1:0] c_val,
    input  logic signed [DW-1:0] s_val,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    output logic signed [DW-1:0] x_new,
    output logic signed [DW-1:0] y_new
);
    localparam int PW = 2*DW;
    localparam int AW = PW + 1;

    logic signed [PW-1:0] cx, sy, cy, sx;
    logic signed [AW-1:0] top_sum, bot_sum;

    assign cx = PW'(c_val) * PW'(x);
    assign sy = PW'(s_val) * PW'(y);
    assign cy = PW'(c_val) * PW'(y);
    assign sx = PW'(s_val) * PW'(x);

    assign top_sum = {cx[PW-1], cx} + {sy[PW-1], sy};
    assign bot_sum = {cy[PW-1], cy} - {sx[PW-1], sx};

    gc_round_sat #(.IW(AW), .SH(CF), .OW(DW)) u_rs_top (.din(top_sum), .dout(x_new));
    gc_round_sat #(.IW(AW), .SH(CF), .OW(DW)) u_rs_bot (.din(bot_sum), .dout(y_new));
endmodule

// File: rtl/givens_cell.sv
module givens_cell
    import givens_pkg::*;
#(
    parameter int DW = 16,
    parameter int DF = 12,
    parameter int CF = 14,
    parameter int RW = 16,
    parameter int RF = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 piv_valid,
    input  logic signed [DW-1:0] piv_a,
    input  logic signed [DW-1:0] piv_b,
    output logic                 sq_valid,
    output logic [2*DW-1:0]      sq_sum,
    input  logic                 rsr_valid,
    input  logic [RW-1:0]        rsr_val,
    output logic                 gen_valid,
    output logic signed [DW-1:0] cos_out,
    output logic signed [DW-1:0] sin_out,
    output logic signed [DW-1:0] diag_out,
    output logic [RW-1:0]        diag_recip,
    input  logic                 rot_valid,
    input  logic signed [DW-1:0] rot_top,
    input  logic signed [DW-1:0] rot_bot,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_top,
    output logic signed [DW-1:0] out_bot
);
    localparam int SW = 2*DW;
    localparam logic signed [DW-1:0] COS_ONE = DW'(2**CF);

    gc_state_e state, state_nx;

    logic signed [DW-1:0] a_q, b_q;
    logic signed [SW-1:0] a_sq, b_sq;
    logic [SW-1:0]        sum_comb;
    logic                 piv_zero;
    logic signed [DW-1:0] c_calc, s_calc, r_calc;
    logic signed [DW-1:0] top_calc, bot_calc;

    assign a_sq     = SW'(piv_a) * SW'(piv_a);
    assign b_sq     = SW'(piv_b) * SW'(piv_b);
    assign sum_comb = $unsigned(a_sq) + $unsigned(b_sq);
    assign piv_zero = (piv_a == '0) && (piv_b == '0);

    gc_boundary #(.DW(DW), .DF(DF), .CF(CF), .RW(RW), .RF(RF)) u_boundary (
        .a(a_q), .b(b_q), .sumsq(sq_sum), .rsr(rsr_val),
        .c_val(c_calc), .s_val(s_calc), .r_val(r_calc)
    );

    gc_rotator #(.DW(DW), .CF(CF)) u_rotator (
        .c_val(cos_out), .s_val(sin_out), .x(rot_top), .y(rot_bot),
        .x_new(top_calc), .y_new(bot_calc)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (piv_valid) begin
            state_nx = piv_zero ? ST_READY : ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_WAIT:  if (rsr_valid) state_nx = ST_READY;
                ST_READY: state_nx = ST_READY;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q        <= '0;
            b_q        <= '0;
            sq_valid   <= 1'b0;
            sq_sum     <= '0;
            gen_valid  <= 1'b0;
            cos_out    <= '0;
            sin_out    <= '0;
            diag_out   <= '0;
            diag_recip <= '0;
            out_valid  <= 1'b0;
            out_top    <= '0;
            out_bot    <= '0;
        end else begin
            sq_valid  <= 1'b0;
            gen_valid <= 1'b0;
            out_valid <= 1'b0;
            if (piv_valid) begin
                if (piv_zero) begin
                    gen_valid  <= 1'b1;
                    cos_out    <= COS_ONE;
                    sin_out    <= '0;
                    diag_out   <= '0;
                    diag_recip <= '0;
                end else begin
                    a_q      <= piv_a;
                    b_q      <= piv_b;
                    sq_sum   <= sum_comb;
                    sq_valid <= 1'b1;
                end
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_WAIT: begin
                        if (rsr_valid) begin
                            gen_valid  <= 1'b1;
                            cos_out    <= c_calc;
                            sin_out    <= s_calc;
                            diag_out   <= r_calc;
                            diag_recip <= rsr_val;
                        end
                    end
                    ST_READY: begin
                        if (rot_valid) begin
                            out_valid <= 1'b1;
                            out_top   <= top_calc;
                            out_bot   <= bot_calc;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SQ_AFTER_PIVOT: assert property (@(posedge clk) disable iff (!rst_n)
        (piv_valid && !piv_zero) |=> (sq_valid && !gen_valid)); // R1
    AST_GEN_AFTER_RSR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && rsr_valid && !piv_valid) |=> gen_valid); // R2
    AST_DIAG_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        gen_valid |-> !diag_out[DW-1]); // R3
    AST_ROT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && rot_valid && !piv_valid) |=> out_valid); // R4
    AST_ZERO_PIVOT: assert property (@(posedge clk) disable iff (!rst_n)
        (piv_valid && piv_zero) |=> (gen_valid && !sq_valid && cos_out == COS_ONE && sin_out == '0)); // R5
    AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_valid |-> ($stable(cos_out) && $stable(sin_out) && $stable(diag_recip))); // R6
    AST_NO_ROT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY && !piv_valid) |=> !out_valid); // R7
    AST_PIVOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        piv_valid |=> !out_valid); // R8
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sq_valid, gen_valid, out_valid})); // R8
endmodule

// File: tb/givens_cell_bench.sv
module givens_cell_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic piv_valid, rsr_valid, rot_valid;
    logic signed [15:0] piv_a, piv_b, rot_top, rot_bot;
    logic [15:0] rsr_val;
    logic sq_valid, gen_valid, out_valid;
    logic [31:0] sq_sum;
    logic signed [15:0] cos_out, sin_out, diag_out, out_top, out_bot;
    logic [15:0] diag_recip;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    givens_cell u_givens_cell (
        .clk(clk), .rst_n(rst_n),
        .piv_valid(piv_valid), .piv_a(piv_a), .piv_b(piv_b),
        .sq_valid(sq_valid), .sq_sum(sq_sum),
        .rsr_valid(rsr_valid), .rsr_val(rsr_val),
        .gen_valid(gen_valid), .cos_out(cos_out), .sin_out(sin_out),
        .diag_out(diag_out), .diag_recip(diag_recip),
        .rot_valid(rot_valid), .rot_top(rot_top), .rot_bot(rot_bot),
        .out_valid(out_valid), .out_top(out_top), .out_bot(out_bot)
    );

    function automatic longint rsat(longint v, int sh);
        longint t;
        t = (v + (64'sd1 <<< (sh - 1))) >>> sh;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(string req, string what, longint act, longint exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // drive one cycle of strobes at a falling edge; return at the next falling edge
    task automatic step(bit pv, int a, int b, bit rv, int r, bit ov, int x, int y);
        @(negedge clk);
        piv_valid = pv; piv_a = 16'(a); piv_b = 16'(b);
        rsr_valid = rv; rsr_val = 16'(r);
        rot_valid = ov; rot_top = 16'(x); rot_bot = 16'(y);
        @(negedge clk);
        piv_valid = 1'b0; rsr_valid = 1'b0; rot_valid = 1'b0;
    endtask

    task automatic do_reset();
        piv_valid = 0; rsr_valid = 0; rot_valid = 0;
        piv_a = 0; piv_b = 0; rsr_val = 0; rot_top = 0; rot_bot = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq("R9", "cos", cos_out, 0);
        chk_eq("R9", "sin", sin_out, 0);
        chk_eq("R9", "diag", diag_out, 0);
        chk_eq("R9", "recip", diag_recip, 0);
        chk_eq("R9", "out_top", out_top, 0);
        chk_eq("R9", "pulses", {sq_valid, gen_valid, out_valid}, 0);
    endtask

    task automatic t_basic();
        longint c, s;
        step(1, 3000, -4000, 0, 0, 0, 0, 0);
        chk_eq("R1", "sq_valid", sq_valid, 1);
        chk_eq("R1", "sq_sum", longint'(sq_sum), 25000000);
        chk_eq("R1", "gen_valid", gen_valid, 0);
        step(0, 0, 0, 1, 3355, 0, 0, 0);
        c = rsat(64'sd3000 * 3355, 10);
        s = rsat(-64'sd4000 * 3355, 10);
        chk_eq("R2", "gen_valid", gen_valid, 1);
        chk_eq("R2", "cos", cos_out, c);
        chk_eq("R2", "sin", sin_out, s);
        chk_eq("R3", "diag", diag_out, rsat(64'sd25000000 * 3355, 24));
        chk_eq("R3", "recip", diag_recip, 3355);
        step(0, 0, 0, 0, 0, 1, 1000, 2000);
        chk_eq("R4", "out_valid", out_valid, 1);
        chk_eq("R4", "top", out_top, rsat(c * 1000 + s * 2000, 14));
        chk_eq("R4", "bot", out_bot, rsat(c * 2000 - s * 1000, 14));
    endtask

    task automatic t_hold();
        longint c, s;
        c = cos_out; s = sin_out;
        step(0, 0, 0, 0, 0, 1, -5000, 700);
        chk_eq("R6", "top", out_top, rsat(c * -5000 + s * 700, 14));
        chk_eq("R6", "bot", out_bot, rsat(c * 700 - s * -5000, 14));
        step(0, 0, 0, 0, 0, 1, 3000, -4000);
        chk_eq("R6", "cos held", cos_out, c);
        chk_eq("R6", "pivot bot", out_bot, rsat(c * -4000 - s * 3000, 14));
    endtask

    task automatic t_zero();
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk_eq("R5", "sq_valid", sq_valid, 0);
        chk_eq("R5", "gen_valid", gen_valid, 1);
        chk_eq("R5", "cos", cos_out, 16384);
        chk_eq("R5", "sin", sin_out, 0);
        chk_eq("R5", "diag", diag_out, 0);
        chk_eq("R5", "recip", diag_recip, 0);
        step(0, 0, 0, 0, 0, 1, 1234, -777);
        chk_eq("R5", "top unchanged", out_top, 1234);
        chk_eq("R5", "bot unchanged", out_bot, -777);
    endtask

    task automatic t_ignore();
        do_reset();
        step(0, 0, 0, 0, 0, 1, 500, 600);
        chk_eq("R7", "out_valid idle", out_valid, 0);
        chk_eq("R7", "out_top idle", out_top, 0);
        step(0, 0, 0, 1, 2000, 0, 0, 0);
        chk_eq("R7", "gen idle", gen_valid, 0);
        chk_eq("R7", "recip idle", diag_recip, 0);
        step(1, 2048, 2048, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 500, 600);
        chk_eq("R7", "out_valid wait", out_valid, 0);
        chk_eq("R7", "out_bot wait", out_bot, 0);
        step(0, 0, 0, 1, 5793, 0, 0, 0);
        chk_eq("R2", "cos 45deg", cos_out, rsat(64'sd2048 * 5793, 10));
        step(0, 0, 0, 1, 100, 0, 0, 0);
        chk_eq("R7", "gen ready", gen_valid, 0);
        chk_eq("R7", "recip ready", diag_recip, 5793);
    endtask

    task automatic t_restart();
        step(1, 1000, 1000, 0, 0, 0, 0, 0);
        step(1, 4000, 300, 1, 999, 1, 10, 10);
        chk_eq("R8", "sq_valid", sq_valid, 1);
        chk_eq("R8", "gen_valid", gen_valid, 0);
        chk_eq("R8", "out_valid", out_valid, 0);
        chk_eq("R8", "sq_sum", longint'(sq_sum), 16090000);
        step(0, 0, 0, 1, 4182, 0, 0, 0);
        chk_eq("R8", "cos new pivot", cos_out, rsat(64'sd4000 * 4182, 10));
        chk_eq("R8", "sin new pivot", sin_out, rsat(64'sd300 * 4182, 10));
        step(1, 700, 700, 0, 0, 1, 5, 5);
        chk_eq("R8", "rot over pivot", out_valid, 0);
    endtask

    task automatic t_saturate();
        longint c;
        step(1, 20000, 20000, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 593, 0, 0, 0);
        c = rsat(64'sd20000 * 593, 10);
        chk_eq("R10", "cos", cos_out, c);
        step(0, 0, 0, 0, 0, 1, 32767, 32767);
        chk_eq("R10", "top high clamp", out_top, 32767);
        chk_eq("R10", "bot", out_bot, rsat(c * 32767 - c * 32767, 14));
        step(0, 0, 0, 0, 0, 1, -32768, -32768);
        chk_eq("R10", "top low clamp", out_top, -32768);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_zero();
        t_ignore();
        t_restart();
        t_saturate();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule